// File: doc/BRIEF.md
# Bus Activity and First-Cycle Protect Detector

This block watches the address strobe of a shared bus on behalf of a bus arbiter. It produces two flags. `busy` means a bus cycle is in progress, so the arbiter must not issue or move any grant. `guard` marks the first external cycle that follows a stretch of bus inactivity. The arbiter must keep that cycle's grant in place, or give it back to the master that had it, until the cycle ends.

The strobe is sampled on the falling edge of the owning master's clock output. A low sample means the bus is idle. When the strobe rises after an idle sample, `guard` goes high at once, without waiting for any clock edge. This covers two cases: the first cycle after a grant is handed over, and an external cycle that follows internal cycles. `guard` holds for as long as the strobe stays high and drops the moment the strobe falls. If the strobe falls and rises again before a falling edge has seen it low, the new cycle is part of a back-to-back run and is not protected.

The reset input clears both flags at once. Its release is passed through a short synchronizer clocked on the same falling edge. The arbitration decision itself sits outside this block.

Top module: `bus_cycle_watch`

## Requirements
- R1: While `rst_n` is low, `busy` and `guard` are both low, whatever the strobe does, and asserting `rst_n` low clears them without waiting for a clock edge.
- R2: Once out of reset, `busy` equals the level of `strobe` at the most recent falling edge of `mclk` (1 = bus cycle in progress, 0 = idle).
- R3: A rise of `rst_n` takes effect internally at the SYNC_STAGES-th falling edge of `mclk` after it (the 2nd with the default). Until then both outputs stay low, and `busy` first follows the strobe at the falling edge after that.
- R4: When `strobe` is high and the latest falling-edge sample was idle (`busy` low), `guard` is high at once, without waiting for a clock edge.
- R5: Once raised, `guard` stays high across any number of falling edges for as long as `strobe` stays high.
- R6: When `strobe` falls, `guard` goes low at once, without waiting for a clock edge.
- R7: If `strobe` rises again before any falling edge has sampled it low (`busy` still high), `guard` stays low for the whole of that strobe-high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Clock output of the master that owns the bus; sampling happens on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| strobe | input | 1 | Address strobe of the shared bus, high during the address phase of an external cycle |
| busy | output | 1 | Bus cycle in progress; the arbiter must not change grants while high |
| guard | output | 1 | First external cycle after inactivity; the arbiter must keep or restore the current grant |

## Verification
The clocked assertions assume that `strobe` and the rise of `rst_n` never change close to a falling edge of `mclk`, so every falling-edge sample sees a settled level. The bench honours this. It changes `strobe` either half a nanosecond after a rising edge or partway through the high phase, and it releases reset just after a rising edge. Every low strobe level set after a rising edge lasts through the next falling edge. The one exception is the deliberate short dip, which opens and closes before the falling edge so that the back-to-back case can be exercised.

// File: rtl/bcw_pkg.sv
package bcw_pkg;

  // Default depth of the reset release synchronizer.
  localparam int unsigned BCW_SYNC_DEFAULT = 2;

  // Flags handed from the detector to the arbiter.
  typedef struct packed {
    logic busy;   // cycle in progress, grants frozen
    logic guard;  // first cycle after idle, grant held
  } bcw_flags_t;

endpackage

// File: rtl/bcw_rst_sync.sv
module bcw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        sync_d = 1'b1;
      end
    end else begin : g_chain
      always_comb begin
        sync_d = {sync_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[LAST];

  // R3
  release_delay_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n));

endmodule

// File: rtl/bcw_sampler.sv
module bcw_sampler (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic strobe,
  output logic busy_o
);

  logic busy_q;
  logic busy_d;

  always_comb begin
    busy_d = strobe;
  end

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  // R2
  sample_track_chk: assert property (@(negedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (busy_o == $past(strobe)));

endmodule

// File: rtl/bcw_guard.sv
module bcw_guard (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic strobe,
  input  logic busy_i,
  output logic guard_o
);

  // Held-protection flag: set at a falling edge inside a protected cycle,
  // wiped asynchronously as soon as the strobe drops.
  logic held_q;
  logic held_d;
  logic clr_n;
  logic opening;

  assign clr_n   = rst_sync_n & strobe;
  assign opening = ~busy_i;

  always_comb begin
    held_d = held_q | opening;
  end

  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

  assign guard_o = clr_n & (held_q | opening);

  // R6
  fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !strobe |-> !guard_o);

  // R7
  late_rise_chk: assert property (@(negedge clk) disable iff (!rst_sync_n)
    $rose(guard_o) |-> !busy_i);

endmodule

// File: rtl/bus_cycle_watch.sv
module bus_cycle_watch
  import bcw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = BCW_SYNC_DEFAULT
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic strobe,
  output logic busy,
  output logic guard
);

  logic       rst_sync_n;
  bcw_flags_t flags;

  bcw_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst (
    .clk       (mclk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  bcw_sampler u_smp (
    .clk       (mclk),
    .rst_sync_n(rst_sync_n),
    .strobe    (strobe),
    .busy_o    (flags.busy)
  );

  bcw_guard u_grd (
    .clk       (mclk),
    .rst_sync_n(rst_sync_n),
    .strobe    (strobe),
    .busy_i    (flags.busy),
    .guard_o   (flags.guard)
  );

  assign busy  = flags.busy;
  assign guard = flags.guard;

  // R1
  reset_quiet_chk: assert property (@(posedge mclk)
    !rst_n |-> (!busy && !guard));

  // R4
  first_cycle_chk: assert property (@(negedge mclk) disable iff (!rst_sync_n)
    (strobe && !busy) |-> guard);

endmodule

// File: tb/sim_bus_cycle_watch.sv
`timescale 1ns/100ps
module sim_bus_cycle_watch;

  logic mclk;
  logic rst_n;
  logic strobe;
  logic busy;
  logic guard;

  int checks;
  int fails;
  bit done;

  // {strobe to drive, expected busy, expected guard}
  localparam logic [2:0] VEC [12] = '{
    3'b000, 3'b000, 3'b101, 3'b111, 3'b111, 3'b010,
    3'b101, 3'b010, 3'b000, 3'b101, 3'b111, 3'b010
  };

  bus_cycle_watch u0 (
    .mclk  (mclk),
    .rst_n (rst_n),
    .strobe(strobe),
    .busy  (busy),
    .guard (guard)
  );

  initial begin
    mclk = 1'b0;
    forever #2.5 mclk = ~mclk;
  end

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic after_neg();
    @(negedge mclk);
    #1;
  endtask

  task automatic after_pos();
    @(posedge mclk);
    #0.5;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    strobe = 1'b1;
    #1;
    check("R1", "busy in reset", busy, 1'b0);
    check("R1", "guard in reset", guard, 1'b0);

    // Release reset with the strobe already high.
    after_pos();
    rst_n = 1'b1;
    after_neg();
    check("R3", "guard before 2nd edge", guard, 1'b0);
    check("R3", "busy before 2nd edge", busy, 1'b0);
    after_neg();
    check("R3", "guard after release", guard, 1'b1);
    check("R3", "busy on release edge", busy, 1'b0);
    after_neg();
    check("R2", "busy follows sample", busy, 1'b1);

    after_pos();
    strobe = 1'b0;
    #0.3;
    check("R6", "guard drops on fall", guard, 1'b0);
    after_neg();
    check("R2", "busy idle sample", busy, 1'b0);
    after_neg();

    // Table walk: strobe changes just after rising edges.
    for (int i = 0; i < 12; i++) begin
      after_pos();
      strobe = VEC[i][2];
      #0.5;
      check("R2", $sformatf("busy vec %0d", i), busy, VEC[i][1]);
      check("R4/R5/R6 R4 R5 R6", $sformatf("guard vec %0d", i), guard, VEC[i][0]);
    end

    // Back-to-back cycle: a dip the falling edge never sees.
    after_pos();
    strobe = 1'b1;
    #0.5;
    check("R4", "guard on first rise", guard, 1'b1);
    after_neg();
    check("R5", "guard held over edge", guard, 1'b1);
    check("R2", "busy high in cycle", busy, 1'b1);
    after_pos();
    strobe = 1'b0;
    #0.3;
    check("R6", "guard drops mid phase", guard, 1'b0);
    #0.4;
    strobe = 1'b1;
    #0.3;
    check("R7", "guard on late rise", guard, 1'b0);
    check("R7", "busy kept high", busy, 1'b1);
    after_neg();
    check("R7", "guard after next edge", guard, 1'b0);
    after_neg();
    check("R7", "guard two edges on", guard, 1'b0);
    check("R2", "busy still high", busy, 1'b1);

    // Idle sample restores protection on the next rise.
    after_pos();
    strobe = 1'b0;
    after_neg();
    check("R2", "busy idle again", busy, 1'b0);
    after_pos();
    strobe = 1'b1;
    #0.5;
    check("R4", "guard after idle sample", guard, 1'b1);
    after_neg();
    check("R5", "guard held again", guard, 1'b1);

    // Reset in mid-cycle.
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R1", "busy cleared by reset", busy, 1'b0);
    check("R1", "guard cleared by reset", guard, 1'b0);
    after_neg();
    check("R1", "guard held low in reset", guard, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule